// File: doc/BRIEF.md
# Read/Write Bus Turnaround Arbiter

This block decides, for one memory channel, whether the shared data bus carries reads or writes on the next burst. It watches the occupancy of the channel's read and write queues, a drain request and a write-block flag, and acts once on every burst-decision strobe. Between strobes it holds its state. One instance serves each pseudo channel, and instances share nothing.

Direction changes use hysteresis. Writes can take the bus early only when reads have run dry and the write queue is past a low mark. While reads are still pending, writes must pass a high mark after a minimum run of reads. Write mode gives the bus back when writes are exhausted, drop well under the low mark, have had their minimum run while reads wait, or are blocked while reads wait. Both marks are percentages of half the write buffer, since each pseudo channel owns half. When a turnaround takes effect, the block reports how many bursts the direction being left served, then clears that count.

Top module: `bus_turn_arb`

## Requirements
- R1: After synchronous active-low reset, `dir_cur` and `dir_next` are READ (encoded 0; WRITE is 1), `turn_pulse` is 0 and `turn_count` is 0.
- R2: In a cycle without `burst_stb`, `dir_cur`, `dir_next` and `turn_count` keep their values and `turn_pulse` is 0 in the following cycle.
- R3: On a cycle with `burst_stb`, `dir_cur` takes the value `dir_next` had in that cycle.
- R4: If `dir_cur` differs from `dir_next` at a strobe, `turn_pulse` is 1 for the following cycle only. `turn_count` then shows the bursts counted in the direction being left, and that direction's counter restarts at zero.
- R5: At a strobe, one burst is counted in the direction taken (the old `dir_next`) only if that direction's queue occupancy is non-zero.
- R6: With READ taken and the read occupancy at zero, `dir_next` becomes WRITE exactly when the write occupancy is non-zero and either `drain_req` is set or the write occupancy exceeds the low threshold.
- R7: With READ taken and reads pending, `dir_next` becomes WRITE exactly when the write occupancy exceeds the high threshold and `wr_block` is clear and, counting this burst, the read run has reached `MIN_RD` or no reads remain after it.
- R8: With WRITE taken, let W be the write occupancy less this burst. `dir_next` becomes READ when any one of these holds: W is zero; W plus `MIN_WR` is below the low threshold and there is no drain; reads are waiting and the write run, counting this burst, has reached `MIN_WR`; reads are waiting and `wr_block` is set.
- R9: The high and low thresholds equal `WBUF_DEPTH/2` times the percentage over 100, truncated to an integer. With the defaults 64, 85 and 50 they are 27 and 16.
- R10: Burst counters saturate at 2^`CNT_W`-1 and do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_occ | input | OCC_W | Read queue occupancy of this channel |
| wr_occ | input | OCC_W | Write queue occupancy of this channel |
| drain_req | input | 1 | Request to empty the write queue |
| wr_block | input | 1 | Writes cannot currently issue |
| burst_stb | input | 1 | Burst-decision strobe |
| dir_cur | output | 1 | Direction in force (0 READ, 1 WRITE) |
| dir_next | output | 1 | Direction for the next decision |
| turn_pulse | output | 1 | One-cycle flag that a turnaround took effect |
| turn_count | output | CNT_W | Bursts served in the direction just ended |

## Verification
Two things happen on the same strobe. The turnaround that was queued earlier takes effect, which reports and clears the old counter. In that same cycle the burst in the new direction is counted and the next direction is decided from the updated count. The bench provokes this by setting up a pending switch and then striking the strobe with occupancies that either trigger or suppress an immediate return. It checks that `turn_count`, `dir_cur` and `dir_next` all match an arithmetic model of the requirements after that single edge. Exhaustive sweeps of occupancy, drain and block in both directions, plus a long pseudo-random stream, compare every output cycle by cycle.

// File: rtl/bus_turn_pkg.sv
package bus_turn_pkg;
    // Bus direction encoding shared by all units
    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_t;
endpackage

// File: rtl/bus_turn_ctr.sv
// Saturating burst counter for one bus direction.
// Assumes clr and inc are only raised on a decision strobe.
// q_nxt exposes the value the counter will take at the next edge,
// so the switching rule can see a count that includes the current burst.
module bus_turn_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] q,
    output logic [CNT_W-1:0] q_nxt
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

    logic [CNT_W-1:0] base;

    // Next count: clear first, then add one unless saturated
    always_comb begin
        base  = clr ? '0 : q;
        q_nxt = (inc && base != SAT) ? base + 1'b1 : base;
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end
endmodule

// File: rtl/bus_turn_rule.sv
// Combinational switching rule: given the direction being taken on
// this strobe, the occupancies and the updated run counts, say whether
// the following decision should be a write. Occupancies are as seen
// before this strobe's burst leaves its queue.
module bus_turn_rule
    import bus_turn_pkg::*;
#(
    parameter int OCC_W  = 8,
    parameter int CNT_W  = 16,
    parameter int HI_TH  = 27,
    parameter int LO_TH  = 16,
    parameter int MIN_RD = 64,
    parameter int MIN_WR = 64
) (
    input  dir_t             dir,
    input  logic [OCC_W-1:0] rd_occ,
    input  logic [OCC_W-1:0] wr_occ,
    input  logic             drain,
    input  logic             wblock,
    input  logic [CNT_W-1:0] rd_run,
    input  logic [CNT_W-1:0] wr_run,
    output logic             go_wr
);
    int rd_n, wr_n, rd_left, wr_left, rd_run_n, wr_run_n;
    logic to_rd;

    // Evaluate the hysteresis conditions for the direction in force
    always_comb begin
        rd_n     = int'(rd_occ);
        wr_n     = int'(wr_occ);
        rd_run_n = int'(rd_run);
        wr_run_n = int'(wr_run);
        rd_left  = (rd_n != 0) ? rd_n - 1 : 0;
        wr_left  = (wr_n != 0) ? wr_n - 1 : 0;
        to_rd    = 1'b0;
        go_wr    = 1'b0;
        if (dir == DIR_RD) begin
            if (rd_n == 0)
                go_wr = (wr_n != 0) && (drain || wr_n > LO_TH);
            else
                go_wr = (wr_n > HI_TH) && !wblock &&
                        (rd_run_n >= MIN_RD || rd_left == 0);
        end else begin
            to_rd = (wr_left == 0) ||
                    ((wr_left + MIN_WR < LO_TH) && !drain) ||
                    ((rd_n != 0) && (wr_run_n >= MIN_WR)) ||
                    ((rd_n != 0) && wblock);
            go_wr = !to_rd;
        end
    end
endmodule

// File: rtl/bus_turn_arb.sv
// Read/write turnaround arbiter for one pseudo channel.
// On each burst_stb the queued direction takes effect, a burst is
// counted in it when its queue is non-empty, and the next direction is
// decided. Assumes occupancies are stable around the strobe edge.
module bus_turn_arb
    import bus_turn_pkg::*;
#(
    parameter int WBUF_DEPTH = 64,
    parameter int HI_PCT     = 85,
    parameter int LO_PCT     = 50,
    parameter int MIN_RD     = 64,
    parameter int MIN_WR     = 64,
    parameter int OCC_W      = 8,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] rd_occ,
    input  logic [OCC_W-1:0] wr_occ,
    input  logic             drain_req,
    input  logic             wr_block,
    input  logic             burst_stb,
    output logic             dir_cur,
    output logic             dir_next,
    output logic             turn_pulse,
    output logic [CNT_W-1:0] turn_count
);
    localparam int HALF  = WBUF_DEPTH / 2;
    localparam int HI_TH = (HALF * HI_PCT) / 100;
    localparam int LO_TH = (HALF * LO_PCT) / 100;

    dir_t             cur_q, nxt_q;
    logic             swap;
    logic             issued;
    logic             go_wr;
    logic [CNT_W-1:0] run_q [2];
    logic [CNT_W-1:0] run_d [2];

    // Turnaround pending and whether the taken direction has work
    always_comb begin
        swap   = (cur_q != nxt_q);
        issued = (nxt_q == DIR_RD) ? (rd_occ != '0) : (wr_occ != '0);
    end

    // One run counter per direction
    for (genvar g = 0; g < 2; g++) begin : g_run
        bus_turn_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (burst_stb && swap && (cur_q == dir_t'(g))),
            .inc   (burst_stb && issued && (nxt_q == dir_t'(g))),
            .q     (run_q[g]),
            .q_nxt (run_d[g])
        );
    end

    bus_turn_rule #(
        .OCC_W  (OCC_W),
        .CNT_W  (CNT_W),
        .HI_TH  (HI_TH),
        .LO_TH  (LO_TH),
        .MIN_RD (MIN_RD),
        .MIN_WR (MIN_WR)
    ) u_rule (
        .dir    (nxt_q),
        .rd_occ (rd_occ),
        .wr_occ (wr_occ),
        .drain  (drain_req),
        .wblock (wr_block),
        .rd_run (run_d[0]),
        .wr_run (run_d[1]),
        .go_wr  (go_wr)
    );

    // Direction state, turnaround flag and reported run length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q      <= DIR_RD;
            nxt_q      <= DIR_RD;
            turn_pulse <= 1'b0;
            turn_count <= '0;
        end else begin
            turn_pulse <= burst_stb && swap;
            if (burst_stb) begin
                cur_q <= nxt_q;
                nxt_q <= go_wr ? DIR_WR : DIR_RD;
                if (swap)
                    turn_count <= (cur_q == DIR_WR) ? run_q[1] : run_q[0];
            end
        end
    end

    // Drive the direction ports
    always_comb begin
        dir_cur  = cur_q;
        dir_next = nxt_q;
    end
endmodule

// File: rtl/bus_turn_arb_chk.sv
// Port-level temporal checks for bus_turn_arb, bound to every instance.
module bus_turn_arb_chk #(
    parameter int OCC_W = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OCC_W-1:0] rd_occ,
    input logic [OCC_W-1:0] wr_occ,
    input logic             burst_stb,
    input logic             dir_cur,
    input logic             dir_next,
    input logic             turn_pulse,
    input logic [CNT_W-1:0] turn_count
);
    a_r2_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_stb |=> $stable(dir_cur) && $stable(dir_next) && $stable(turn_count));

    a_r2_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_stb |=> !turn_pulse);

    a_r3_follow_next: assert property (@(posedge clk) disable iff (!rst_n)
        burst_stb |=> dir_cur == $past(dir_next));

    a_r4_pulse_on_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stb && dir_cur != dir_next) |=> turn_pulse);

    a_r4_no_pulse_same: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stb && dir_cur == dir_next) |=> !turn_pulse);

    a_r6_stay_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stb && !dir_next && rd_occ == '0 && wr_occ == '0) |=> !dir_next);

    a_r8_leave_empty_write: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stb && dir_next && wr_occ == '0) |=> !dir_next);
endmodule

bind bus_turn_arb bus_turn_arb_chk #(.OCC_W(OCC_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_occ     (rd_occ),
    .wr_occ     (wr_occ),
    .burst_stb  (burst_stb),
    .dir_cur    (dir_cur),
    .dir_next   (dir_next),
    .turn_pulse (turn_pulse),
    .turn_count (turn_count)
);

// File: tb/test_bus_turn_arb.sv
module test_bus_turn_arb;
    localparam int WB = 16, HP = 75, LP = 50, MR = 3, MW = 2, OW = 4, CW = 3;
    localparam int HI = ((WB / 2) * HP) / 100;   // 6
    localparam int LO = ((WB / 2) * LP) / 100;   // 4
    localparam int SAT = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [OW-1:0] rd_occ = '0, wr_occ = '0;
    logic drain_req = 1'b0, wr_block = 1'b0, burst_stb = 1'b0;
    logic dir_cur, dir_next, turn_pulse;
    logic [CW-1:0] turn_count;

    int checks = 0, errors = 0;
    int m_cur, m_nxt, m_rc, m_wc, m_pulse, m_cnt;
    string m_tag;

    always #10 clk = ~clk;

    bus_turn_arb #(.WBUF_DEPTH(WB), .HI_PCT(HP), .LO_PCT(LP), .MIN_RD(MR),
                   .MIN_WR(MW), .OCC_W(OW), .CNT_W(CW)) i_bus_turn_arb (
        .clk(clk), .rst_n(rst_n), .rd_occ(rd_occ), .wr_occ(wr_occ),
        .drain_req(drain_req), .wr_block(wr_block), .burst_stb(burst_stb),
        .dir_cur(dir_cur), .dir_next(dir_next), .turn_pulse(turn_pulse),
        .turn_count(turn_count));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference behaviour written from the requirements
    task automatic model(input bit s, input int r, input int w, input bit d, input bit b);
        int sw, take, rl, wl, rd_now, to_wr;
        m_pulse = 0;
        if (!s) begin m_tag = "R2"; return; end
        sw = (m_cur != m_nxt);
        m_pulse = sw;
        if (sw) begin
            m_cnt = m_cur ? m_wc : m_rc;
            if (m_cur) m_wc = 0; else m_rc = 0;
        end
        take = m_nxt;
        m_cur = take;
        if (take == 0 && r != 0 && m_rc < SAT) m_rc++;
        if (take == 1 && w != 0 && m_wc < SAT) m_wc++;
        rl = (r != 0) ? r - 1 : 0;
        wl = (w != 0) ? w - 1 : 0;
        if (take == 0) begin
            if (r == 0) begin
                m_tag = "R6";
                to_wr = (w != 0) && (d || w > LO);
            end else begin
                m_tag = "R7";
                to_wr = (w > HI) && !b && (m_rc >= MR || rl == 0);
            end
        end else begin
            m_tag = "R8";
            rd_now = (r != 0);
            to_wr = !((wl == 0) || (wl + MW < LO && !d) ||
                      (rd_now && m_wc >= MW) || (rd_now && b));
        end
        m_nxt = to_wr;
    endtask

    // Drive one cycle at the falling edge, check at the next falling edge
    task automatic step(input bit s, input int r, input int w, input bit d, input bit b);
        burst_stb = s; rd_occ = OW'(r); wr_occ = OW'(w); drain_req = d; wr_block = b;
        model(s, r, w, d, b);
        @(negedge clk);
        chk(dir_cur == m_cur[0], s ? "R3" : "R2", int'(dir_cur), m_cur);
        chk(dir_next == m_nxt[0], m_tag, int'(dir_next), m_nxt);
        chk(turn_pulse == m_pulse[0], s ? "R4" : "R2", int'(turn_pulse), m_pulse);
        chk(int'(turn_count) == m_cnt, s ? "R4" : "R2", int'(turn_count), m_cnt);
    endtask

    task automatic do_reset();
        burst_stb = 0; rd_occ = '0; wr_occ = '0; drain_req = 0; wr_block = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_cur = 0; m_nxt = 0; m_rc = 0; m_wc = 0; m_pulse = 0; m_cnt = 0;
    endtask

    initial begin
        logic [15:0] lf;
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk(dir_cur == 1'b0 && dir_next == 1'b0, "R1", int'({dir_cur, dir_next}), 0);
        chk(turn_pulse == 1'b0 && turn_count == '0, "R1", int'(turn_count), 0);

        // R9: low threshold boundary with reads empty
        step(1, 0, LO, 0, 0);
        chk(dir_next == 1'b0, "R9", int'(dir_next), 0);
        step(1, 0, LO + 1, 0, 0);
        chk(dir_next == 1'b1, "R9", int'(dir_next), 1);

        // R5: empty strobes count nothing; two reads then a turnaround
        do_reset();
        repeat (3) step(1, 0, 0, 0, 0);
        repeat (2) step(1, 2, 0, 0, 0);
        step(1, 0, 9, 0, 0);
        step(1, 0, 9, 0, 0);
        chk(turn_pulse == 1'b1 && int'(turn_count) == 2, "R5", int'(turn_count), 2);

        // R10: long read run saturates the counter
        do_reset();
        repeat (10) step(1, 5, 0, 0, 0);
        step(1, 0, 9, 0, 0);
        step(1, 0, 9, 0, 0);
        chk(int'(turn_count) == SAT, "R10", int'(turn_count), SAT);

        // R2: inputs change without a strobe
        repeat (5) step(0, 3, 0, 1, 1);

        // Sweeps in read mode (R6, R7) and write mode (R8)
        for (int r = 0; r < 5; r++)
            for (int w = 0; w < 10; w++)
                for (int db = 0; db < 4; db++) begin
                    do_reset();
                    step(1, r, w, db[0], db[1]);
                    do_reset();
                    step(1, 0, 9, 0, 0);
                    step(1, 0, 9, 0, 0);
                    step(1, r, w, db[0], db[1]);
                    step(1, r, w, db[0], db[1]);
                end

        // Pseudo-random stream, every output compared each cycle
        do_reset();
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[1:0] != 2'b00, int'(lf[4:2]) % 6, int'(lf[9:5]) % 11,
                 lf[10] & lf[11], lf[12] & lf[13]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule